// File: doc/BRIEF.md
# Shared Tuner Core Arbiter

This block sits in front of a single cache-tuning engine and lets a cluster of cores share it. Each core asks for a tuning pass with a request line. The arbiter remembers every request, picks one core at a time in rotating order, and holds that core as the owner of the tuner until the tuner has run its pass. While a core is the owner, its statistics bus is steered into the tuner and any configuration word the tuner produces is written back to that core's own configuration register. When the pass ends, the owner gets a one-cycle completion pulse and the next waiting core is picked.

The cluster size is a build parameter (a power of two: 1, 2, 4, 8 or every core). Larger clusters cost less logic overall, because fewer tuners are built, but add delay, because waiting cores are served one after another. With a single core per cluster, the picker and the multiplexers collapse to wires.

Top module: `tuner_cluster_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `core_grant`, `core_done`, `core_cfg_we`, `tun_start` and every `core_cfg` slice are zero.
- R2: A request from core i (bit i of `core_req`) that is high for a single clock edge is remembered until core i has been served. A later request after its completion pulse is served again.
- R3: Waiting cores are picked in round-robin order. The search starts at the core after the most recently granted one, and at core 0 after reset. A core holding its request high cannot be granted twice while another core is waiting.
- R4: `core_grant` is zero or one-hot, with bit i meaning core i owns the tuner. `tun_core_id` gives the owner's index while a grant is held. `tun_start` is high for exactly the first cycle of each grant.
- R5: A grant begins one cycle after the request is latched. It is held until `tun_busy` has been seen high during the grant and then low at a clock edge. The grant ends at that edge, so a grant lasts (cycles before busy) + (busy cycles) + 1 cycles.
- R6: In the cycle after a grant ends, `core_done` pulses for exactly one cycle on the bit of the core that was served, and that core's request is cleared. No new grant starts in that pulse cycle.
- R7: While a grant is held, `tun_stats` in each cycle equals the owner's slice of `core_stats` (slice i at bits i*SW and up) as it was one cycle earlier.
- R8: `tun_cfg_we` during a grant writes `tun_cfg` into the owner's `core_cfg` slice (slice i at bits i*CFG_W and up). That slice and bit i of `core_cfg_we` change in the next cycle, and the other slices stay unchanged. `tun_cfg_we` with no grant held has no effect.
- R9: A request from the core currently being served is ignored for the whole grant. It does not cause a second pass for that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | NCORES | Per-core tuning request |
| core_stats | input | NCORES*NSTAT*STAT_W | Per-core statistics buses, core i in slice i |
| core_cfg | output | NCORES*CFG_W | Per-core configuration registers, core i in slice i |
| core_cfg_we | output | NCORES | One-cycle pulse when a core's configuration slice was rewritten |
| core_grant | output | NCORES | One-hot owner of the tuner |
| core_done | output | NCORES | One-cycle completion pulse for the served core |
| tun_start | output | 1 | Start pulse to the tuner, first cycle of a grant |
| tun_core_id | output | max(1,log2 NCORES) | Index of the owning core |
| tun_stats | output | NSTAT*STAT_W | Owner's statistics, registered |
| tun_busy | input | 1 | Tuner is running a pass |
| tun_cfg | input | CFG_W | Configuration word from the tuner |
| tun_cfg_we | input | 1 | Tuner writes `tun_cfg` to the owner |

## Verification
The main function is tried with several request patterns. A lone one-cycle request shows that requests are latched. All cores asking at once shows the rotation order after a given last owner. One core holding its request high while another pulses shows that rotation beats a persistent requester. A request from the owner during its own pass shows that such requests are masked. Tuner timings with a short and a long gap before busy separate a grant released on busy from one released on a fixed count. A configuration write with no owner shows that the write-back is gated by the grant. Statistics change every cycle, so a mux that selects the wrong core or the wrong cycle is caught.

// File: rtl/tca_pkg.sv
package tca_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tca_rr_pick.sv
module tca_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  pend,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] pick
);
  generate
    if (N == 1) begin : g_single
      assign any  = pend[0];
      assign pick = '0;
    end else begin : g_rr
      // scan from last+N down to last+1; the nearest successor is written last
      always_comb begin
        any  = 1'b0;
        pick = last;
        for (int k = N; k >= 1; k--) begin
          if (pend[(int'(last) + k) % N]) begin
            any  = 1'b1;
            pick = IW'((int'(last) + k) % N);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tca_stat_mux.sv
module tca_stat_mux #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int W  = 16
) (
  input  logic [N*W-1:0] bus,
  input  logic [IW-1:0]  sel,
  output logic [W-1:0]   y
);
  generate
    if (N == 1) begin : g_wire
      assign y = bus;
    end else begin : g_mux
      assign y = bus[int'(sel)*W +: W];
    end
  endgenerate
endmodule

// File: rtl/tca_cfg_bank.sv
module tca_cfg_bank #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int CW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   sel,
  input  logic [CW-1:0]   din,
  output logic [N*CW-1:0] cfg,
  output logic [N-1:0]    cfg_we
);
  for (genvar i = 0; i < N; i++) begin : g_core
    logic hit;
    assign hit = we && (int'(sel) == i);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i*CW +: CW] <= '0;
        cfg_we[i]       <= 1'b0;
      end else begin
        cfg_we[i] <= hit;
        if (hit) cfg[i*CW +: CW] <= din;
      end
    end
  end
endmodule

// File: rtl/tuner_cluster_arbiter.sv
module tuner_cluster_arbiter #(
  parameter int NCORES = 4,
  parameter int NSTAT  = 2,
  parameter int STAT_W = 8,
  parameter int CFG_W  = 6
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NCORES-1:0]                   core_req,
  input  logic [NCORES*NSTAT*STAT_W-1:0]      core_stats,
  output logic [NCORES*CFG_W-1:0]             core_cfg,
  output logic [NCORES-1:0]                   core_cfg_we,
  output logic [NCORES-1:0]                   core_grant,
  output logic [NCORES-1:0]                   core_done,
  output logic                                tun_start,
  output logic [tca_pkg::idx_w(NCORES)-1:0]   tun_core_id,
  output logic [NSTAT*STAT_W-1:0]             tun_stats,
  input  logic                                tun_busy,
  input  logic [CFG_W-1:0]                    tun_cfg,
  input  logic                                tun_cfg_we
);
  localparam int IW = tca_pkg::idx_w(NCORES);
  localparam int SW = NSTAT * STAT_W;

  logic [NCORES-1:0] pend;
  logic              active;
  logic              seen;
  logic [IW-1:0]     owner;
  logic              any;
  logic [IW-1:0]     pick;
  logic [IW-1:0]     owner_nx;
  logic [NCORES-1:0] own_oh;
  logic              release_now;
  logic              grant_now;
  logic [SW-1:0]     stat_sel;

  assign own_oh      = NCORES'(1) << owner;
  assign release_now = active && seen && !tun_busy;
  assign grant_now   = !active && any;
  assign owner_nx    = grant_now ? pick : owner;

  tca_rr_pick #(.N(NCORES), .IW(IW)) u_pick (
    .pend(pend), .last(owner), .any(any), .pick(pick)
  );

  tca_stat_mux #(.N(NCORES), .IW(IW), .W(SW)) u_mux (
    .bus(core_stats), .sel(owner_nx), .y(stat_sel)
  );

  tca_cfg_bank #(.N(NCORES), .IW(IW), .CW(CFG_W)) u_bank (
    .clk(clk), .rst(rst), .we(tun_cfg_we && active), .sel(owner),
    .din(tun_cfg), .cfg(core_cfg), .cfg_we(core_cfg_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      active     <= 1'b0;
      seen       <= 1'b0;
      owner      <= IW'(NCORES - 1);
      core_grant <= '0;
      core_done  <= '0;
      tun_start  <= 1'b0;
      tun_stats  <= '0;
    end else begin
      // owner's own request is masked for the whole grant
      pend      <= (pend | (core_req & ~(active ? own_oh : '0)))
                   & ~(release_now ? own_oh : '0);
      seen      <= active && !release_now && (seen || tun_busy);
      owner     <= owner_nx;
      tun_start <= grant_now;
      tun_stats <= stat_sel;
      core_done <= release_now ? own_oh : '0;
      if (grant_now) begin
        active     <= 1'b1;
        core_grant <= NCORES'(1) << pick;
      end else if (release_now) begin
        active     <= 1'b0;
        core_grant <= '0;
      end
    end
  end

  assign tun_core_id = owner;

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_grant));
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    tun_start |=> !tun_start);
  assert_hold_busy_R5: assert property (@(posedge clk) disable iff (rst)
    ((|core_grant) && tun_busy) |=> $stable(core_grant));
  assert_done_owner_R6: assert property (@(posedge clk) disable iff (rst)
    (|core_done) |-> (core_done == $past(core_grant)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (|core_done) |=> (core_done == '0));
  assert_cfg_target_R8: assert property (@(posedge clk) disable iff (rst)
    (|core_cfg_we) |-> (core_cfg_we == $past(core_grant)));
endmodule

// File: tb/tuner_cluster_arbiter_test.sv
module tuner_cluster_arbiter_test;
  localparam int N  = 4;
  localparam int NS = 2;
  localparam int SWD = 8;
  localparam int CW = 6;
  localparam int SW = NS * SWD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    core_req = '0;
  logic [N*SW-1:0] core_stats = '0;
  logic [N*CW-1:0] core_cfg;
  logic [N-1:0]    core_cfg_we, core_grant, core_done;
  logic            tun_start;
  logic [1:0]      tun_core_id;
  logic [SW-1:0]   tun_stats;
  logic            tun_busy = 1'b0;
  logic [CW-1:0]   tun_cfg = '0;
  logic            tun_cfg_we = 1'b0;

  always #10 clk = ~clk;

  tuner_cluster_arbiter #(.NCORES(N), .NSTAT(NS), .STAT_W(SWD), .CFG_W(CW)) uut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_stats(core_stats),
    .core_cfg(core_cfg), .core_cfg_we(core_cfg_we), .core_grant(core_grant),
    .core_done(core_done), .tun_start(tun_start), .tun_core_id(tun_core_id),
    .tun_stats(tun_stats), .tun_busy(tun_busy), .tun_cfg(tun_cfg),
    .tun_cfg_we(tun_cfg_we)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_pend[N];
  bit m_active, m_seen, m_start;
  int m_owner;
  logic [N-1:0] m_grant, m_done, m_cfg_we;
  logic [CW-1:0] m_cfg[N];
  logic [SW-1:0] m_stats;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_cfg[i] = '0; end
      m_active = 0; m_seen = 0; m_start = 0; m_owner = N - 1;
      m_grant = '0; m_done = '0; m_cfg_we = '0; m_stats = '0;
    end else begin
      bit rel, gnt, nx_pend[N];
      int pk;
      rel = m_active && m_seen && !tun_busy;
      gnt = 0; pk = m_owner;
      if (!m_active)
        for (int k = 1; k <= N; k++)
          if (!gnt && m_pend[(m_owner + k) % N]) begin gnt = 1; pk = (m_owner + k) % N; end
      for (int i = 0; i < N; i++) begin
        nx_pend[i] = m_pend[i] || (core_req[i] && !(m_active && i == m_owner));
        if (rel && i == m_owner) nx_pend[i] = 0;
      end
      m_cfg_we = '0;
      if (m_active && tun_cfg_we) begin
        m_cfg[m_owner] = tun_cfg;
        m_cfg_we[m_owner] = 1'b1;
      end
      m_done = '0;
      if (rel) m_done[m_owner] = 1'b1;
      m_seen = m_active && !rel && (m_seen || tun_busy);
      m_start = gnt;
      if (gnt) begin m_active = 1; m_owner = pk; end
      else if (rel) m_active = 0;
      m_grant = '0;
      if (m_active) m_grant[m_owner] = 1'b1;
      m_stats = core_stats[m_owner*SW +: SW];
      for (int i = 0; i < N; i++) m_pend[i] = nx_pend[i];
    end
  end

  // per-cycle comparison and grant log
  int glog[$];
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(core_grant == m_grant, "R4 grant", core_grant, m_grant);
      chk(tun_start == m_start, "R4 start", tun_start, m_start);
      chk(core_done == m_done, "R6 done", core_done, m_done);
      chk(core_cfg_we == m_cfg_we, "R8 cfg_we", core_cfg_we, m_cfg_we);
      if (m_active) begin
        chk(int'(tun_core_id) == m_owner, "R4 core_id", tun_core_id, m_owner);
        chk(tun_stats == m_stats, "R7 stats", tun_stats, m_stats);
      end
      for (int i = 0; i < N; i++)
        chk(core_cfg[i*CW +: CW] == m_cfg[i], "R8 cfg", core_cfg[i*CW +: CW], m_cfg[i]);
      if (tun_start) glog.push_back(int'(tun_core_id));
    end
    core_stats <= {$urandom, $urandom};
  end

  // tuner stand-in
  int tdelay = 1;
  int tbusy  = 3;
  int seq    = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tun_start) begin
        repeat (tdelay) @(negedge clk);
        tun_busy = 1'b1;
        tun_cfg_we = 1'b1;
        tun_cfg = CW'({tun_core_id, 4'(seq)});
        seq++;
        @(negedge clk);
        tun_cfg_we = 1'b0;
        repeat (tbusy - 1) @(negedge clk);
        tun_busy = 1'b0;
      end
    end
  end

  task automatic pulse(input logic [N-1:0] r);
    @(negedge clk); core_req = r;
    @(negedge clk); core_req = '0;
  endtask

  initial begin
    logic [N*CW-1:0] saved;
    int held;
    repeat (3) @(negedge clk);
    chk(core_grant == '0 && core_done == '0 && tun_start == 1'b0, "R1 outputs",
        {core_grant, core_done, tun_start}, 0);
    chk(core_cfg == '0 && core_cfg_we == '0, "R1 cfg", core_cfg, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(core_grant == '0 && core_cfg == '0, "R1 after release", core_grant, 0);

    // R2: single one-cycle request is latched
    pulse(4'b0100);
    repeat (20) @(negedge clk);
    chk(glog.size() == 1 && glog[0] == 2, "R2 latched", glog.size() > 0 ? glog[0] : -1, 2);
    glog.delete();

    // R3: all at once after last owner 2 -> 3,0,1,2
    pulse(4'b1111);
    repeat (60) @(negedge clk);
    chk(glog.size() == 4, "R3 count", glog.size(), 4);
    if (glog.size() == 4) begin
      chk(glog[0] == 3, "R3 order0", glog[0], 3);
      chk(glog[1] == 0, "R3 order1", glog[1], 0);
      chk(glog[2] == 1, "R3 order2", glog[2], 1);
      chk(glog[3] == 2, "R3 order3", glog[3], 2);
    end
    glog.delete();

    // R9: owner re-request during its grant is ignored
    pulse(4'b0001);
    for (int w = 0; w < 20 && core_grant[0] == 1'b0; w++) @(negedge clk);
    pulse(4'b0001);
    repeat (30) @(negedge clk);
    chk(glog.size() == 1, "R9 ignored", glog.size(), 1);
    pulse(4'b0001);
    repeat (20) @(negedge clk);
    chk(glog.size() == 2, "R2 re-request", glog.size(), 2);
    glog.delete();

    // R3: persistent requester 1 versus one-shot 3 (last owner 0)
    @(negedge clk); core_req = 4'b1010;
    @(negedge clk); core_req = 4'b0010;
    repeat (40) @(negedge clk);
    core_req = '0;
    repeat (30) @(negedge clk);
    chk(glog.size() >= 3, "R3 fair count", glog.size(), 3);
    if (glog.size() >= 3) begin
      chk(glog[0] == 1, "R3 fair0", glog[0], 1);
      chk(glog[1] == 3, "R3 fair1", glog[1], 3);
      chk(glog[2] == 1, "R3 fair2", glog[2], 1);
    end
    glog.delete();

    // R8: write with no owner is ignored
    saved = core_cfg;
    @(negedge clk); tun_cfg = 6'h3f; tun_cfg_we = 1'b1;
    @(negedge clk); tun_cfg_we = 1'b0;
    chk(core_cfg == saved && core_cfg_we == '0, "R8 idle write", core_cfg, saved);
    @(negedge clk);
    chk(core_cfg == saved, "R8 idle write later", core_cfg, saved);

    // R5: grant length follows busy, with a slow tuner
    tdelay = 4; tbusy = 2;
    pulse(4'b0100);
    held = 0;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      if (core_grant[2]) held++;
    end
    chk(held == tdelay + tbusy + 1, "R5 hold length", held, tdelay + tbusy + 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule